// File: doc/BRIEF.md
# UART FIFO Interrupt Register Bank

This block sits between a processor bus and a UART frame engine. It is a byte-wide register bank with a 5-bit address. It holds a 16-entry transmit FIFO, which software fills by writing the data register and the frame engine drains. It also holds a 16-entry receive FIFO, which the frame engine fills together with a per-byte error code and software drains by reading the data register. The bank also holds the frame configuration and the 16-bit baud divisor, which it passes straight to the engine.

Two interrupt sources drive a single interrupt line: TX on bit 0 and RX on bit 1. The RX source fires only when the receive occupancy is above a programmable level, and that level can never be set below half the FIFO. Software can force either flag through a write-1-to-set register. A polling routine uses this to drain a lightly filled receive FIFO through the normal interrupt path. A soft-reset control bit empties both FIFOs and clears the flags.

Top module: `uart_fifo_regbank`

## Requirements
- R1: After reset the enable, control, frame, divisor and interrupt enable registers are 0, and FIFO config (0x0B) reads 0x88. Both FIFOs are empty, both flags are 0 and irq_o is low.
- R2: A write to data (0x04) pushes the byte into the TX FIFO. tx_valid_o is high when enable (0x00 bit 0) and TX enable (0x01 bit 1) are set and the FIFO is not empty. tx_byte_o shows the oldest byte, and tx_pop_i removes it. Bytes leave in write order.
- R3: The TX FIFO holds 16 bytes, and FIFO status (0x0A) bit 4 is set when it is full. A data write while it is full is dropped.
- R4: rx_push_i stores rx_byte_i and rx_err_i only when enable and RX enable (0x01 bit 0) are set and the RX FIFO is not full. It holds 16 entries, and any further push is dropped.
- R5: A read of data returns the oldest RX byte and removes it. A read while the RX FIFO is empty returns 0 and changes nothing. Status (0x02) bits [2:0] show the error code of the oldest entry, or 0 when the FIFO is empty.
- R6: FIFO status bit 2 is set exactly when the RX FIFO is empty.
- R7: With FIFO config bit 3 set, FIFO status bit 3 is set when RX occupancy exceeds 8 plus FIFO config bits [2:0]. With bit 3 clear, the RX FIFO holds one entry and status bit 3 means it is not empty.
- R8: With FIFO config bit 7 set, FIFO status bit 7 is set when TX occupancy is at most 8. With bit 7 clear, the TX FIFO holds one entry and status bit 7 means it is empty.
- R9: The TX flag (bit 0) is set while FIFO status bit 7 holds, and the RX flag (bit 1) is set while FIFO status bit 3 holds. A flag stays set until a 1 is written to its bit of the clear register (0x1C). A hardware condition that is still present sets the flag again on the next cycle.
- R10: Writing 1 to a bit of the set register (0x1D) sets that flag, whether or not its condition is present.
- R11: irq_o is high when any flag is set and its bit in the interrupt enable register (0x1E) is also set. Interrupt status (0x1F) reads flag AND enable.
- R12: While control bit 2 is set, both FIFOs are emptied and both flags are cleared.
- R13: Frame config (0x03) and the divisor (0x08 low byte, 0x09 high byte) read back and drive frame_cfg_o and divisor_o. Writes to FIFO status are ignored.
- R14: Status bit 6 is set when the TX FIFO is empty and tx_idle_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| wr_en_i | input | 1 | register write strobe |
| rd_en_i | input | 1 | register read strobe |
| addr_i | input | 5 | register offset |
| wdata_i | input | 8 | write data |
| rdata_o | output | 8 | read data, valid the cycle after rd_en_i |
| tx_byte_o | output | 8 | oldest TX byte |
| tx_valid_o | output | 1 | TX byte available to the frame engine |
| tx_pop_i | input | 1 | frame engine takes the TX byte |
| tx_idle_i | input | 1 | frame engine shifter idle |
| rx_byte_i | input | 8 | received byte |
| rx_err_i | input | 3 | error code of the received byte |
| rx_push_i | input | 1 | received byte strobe |
| port_en_o | output | 1 | port enable to the frame engine |
| frame_cfg_o | output | 8 | frame configuration |
| divisor_o | output | 16 | baud divisor |
| irq_o | output | 1 | interrupt request |

## Verification
The assertions check on every cycle that:
- the TX occupancy never passes the depth;
- a full-FIFO write and an empty-FIFO read leave the occupancy unchanged;
- a flag falls only after a clear write or a soft reset;
- a set write raises its flags on the next cycle;
- soft reset leaves both FIFOs and the flags empty;
- a zero enable mask keeps irq_o low.

The bench scenarios show the rest:
- the byte order through each FIFO;
- the error code riding with each byte;
- the threshold level for all eight settings at every occupancy;
- the single-entry modes;
- a hardware condition re-arming a cleared flag.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;
  localparam int ADDR_W = 5;
  localparam int NSRC   = 2;
  localparam int SRC_TX = 0;
  localparam int SRC_RX = 1;

  localparam logic [ADDR_W-1:0] A_EN    = 5'h00;
  localparam logic [ADDR_W-1:0] A_CTRL  = 5'h01;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h02;
  localparam logic [ADDR_W-1:0] A_FRM   = 5'h03;
  localparam logic [ADDR_W-1:0] A_DATA  = 5'h04;
  localparam logic [ADDR_W-1:0] A_DIVL  = 5'h08;
  localparam logic [ADDR_W-1:0] A_DIVH  = 5'h09;
  localparam logic [ADDR_W-1:0] A_FSTAT = 5'h0A;
  localparam logic [ADDR_W-1:0] A_FCFG  = 5'h0B;
  localparam logic [ADDR_W-1:0] A_FCLR  = 5'h1C;
  localparam logic [ADDR_W-1:0] A_FSET  = 5'h1D;
  localparam logic [ADDR_W-1:0] A_IEN   = 5'h1E;
  localparam logic [ADDR_W-1:0] A_IST   = 5'h1F;

  localparam logic [7:0] FCFG_RST  = 8'h88;
  localparam logic [7:0] FCFG_MASK = 8'h8F;
endpackage

// File: rtl/rb_fifo.sv
module rb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          single_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_push, do_pop;

  assign empty_o = (cnt_o == '0);
  assign full_o  = single_i ? !empty_o : (cnt_o == CW'(DEPTH));
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;
  assign dout_o  = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      case ({do_push, do_pop})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp_q] <= din_i;
  end
endmodule

// File: rtl/rb_irq.sv
module rb_irq #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_all_i,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ien_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[i] <= 1'b0;
      else if (clr_all_i) flag_o[i] <= 1'b0;
      else                flag_o[i] <= set_i[i] | cond_i[i] | (flag_o[i] & ~clr_i[i]);
    end
  end

  assign irq_o = |(flag_o & ien_i);
endmodule

// File: rtl/uart_fifo_regbank.sv
module uart_fifo_regbank
  import uart_rb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = 3,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int HALF = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic [DW-1:0]     tx_byte_o,
  output logic              tx_valid_o,
  input  logic              tx_pop_i,
  input  logic              tx_idle_i,
  input  logic [DW-1:0]     rx_byte_i,
  input  logic [EW-1:0]     rx_err_i,
  input  logic              rx_push_i,
  output logic              port_en_o,
  output logic [7:0]        frame_cfg_o,
  output logic [15:0]       divisor_o,
  output logic              irq_o
);
  logic            en_q;
  logic [2:0]      ctrl_q;
  logic [7:0]      frm_q;
  logic [15:0]     div_q;
  logic [7:0]      fcfg_q;
  logic [NSRC-1:0] ien_q;
  logic [NSRC-1:0] flags;

  logic            srst, rx_fifo_mode, tx_fifo_mode;
  logic [CW-1:0]   tx_cnt, rx_cnt, rx_lvl;
  logic            tx_empty, tx_full, rx_empty, rx_full;
  logic            tx_push, tx_pop, rx_push, rx_pop;
  logic            rx_hi, tx_lo;
  logic [DW+EW-1:0] rx_head;
  logic [EW-1:0]   head_err;
  logic [NSRC-1:0] cond, set_bits, clr_bits;
  logic [7:0]      fstat, stat, rd_mux;

  assign srst         = ctrl_q[2];
  assign rx_fifo_mode = fcfg_q[3];
  assign tx_fifo_mode = fcfg_q[7];

  // register writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ctrl_q <= '0;
      frm_q  <= '0;
      div_q  <= '0;
      fcfg_q <= FCFG_RST;
      ien_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_EN:    en_q         <= wdata_i[0];
        A_CTRL:  ctrl_q       <= wdata_i[2:0];
        A_FRM:   frm_q        <= wdata_i;
        A_DIVL:  div_q[7:0]   <= wdata_i;
        A_DIVH:  div_q[15:8]  <= wdata_i;
        A_FCFG:  fcfg_q       <= wdata_i & FCFG_MASK;
        A_IEN:   ien_q        <= wdata_i[NSRC-1:0];
        default: ;
      endcase
    end
  end

  assign tx_push    = wr_en_i && (addr_i == A_DATA);
  assign tx_valid_o = en_q && ctrl_q[1] && !tx_empty;
  assign tx_pop     = tx_pop_i && tx_valid_o;
  assign rx_push    = rx_push_i && en_q && ctrl_q[0];
  assign rx_pop     = rd_en_i && (addr_i == A_DATA);

  rb_fifo #(.W(DW), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (srst),
    .single_i (!tx_fifo_mode),
    .push_i   (tx_push),
    .din_i    (wdata_i[DW-1:0]),
    .pop_i    (tx_pop),
    .dout_o   (tx_byte_o),
    .cnt_o    (tx_cnt),
    .empty_o  (tx_empty),
    .full_o   (tx_full)
  );

  rb_fifo #(.W(DW + EW), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (srst),
    .single_i (!rx_fifo_mode),
    .push_i   (rx_push),
    .din_i    ({rx_err_i, rx_byte_i}),
    .pop_i    (rx_pop),
    .dout_o   (rx_head),
    .cnt_o    (rx_cnt),
    .empty_o  (rx_empty),
    .full_o   (rx_full)
  );

  // level never below half depth
  assign rx_lvl = CW'(HALF) + CW'(fcfg_q[2:0]);
  assign rx_hi  = rx_fifo_mode ? (rx_cnt > rx_lvl) : !rx_empty;
  assign tx_lo  = tx_fifo_mode ? (tx_cnt <= CW'(HALF)) : tx_empty;

  assign cond[SRC_TX] = tx_lo;
  assign cond[SRC_RX] = rx_hi;
  assign set_bits = (wr_en_i && addr_i == A_FSET) ? wdata_i[NSRC-1:0] : '0;
  assign clr_bits = (wr_en_i && addr_i == A_FCLR) ? wdata_i[NSRC-1:0] : '0;

  rb_irq #(.N(NSRC)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (srst),
    .cond_i    (cond),
    .set_i     (set_bits),
    .clr_i     (clr_bits),
    .ien_i     (ien_q),
    .flag_o    (flags),
    .irq_o     (irq_o)
  );

  assign head_err = rx_empty ? '0 : rx_head[DW+EW-1:DW];
  assign fstat = {tx_lo, 2'b00, tx_full, rx_hi, rx_empty, 2'b00};
  assign stat  = {1'b0, tx_empty & tx_idle_i, 3'b000, 3'(head_err)};

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_EN:    rd_mux = {7'd0, en_q};
      A_CTRL:  rd_mux = {5'd0, ctrl_q};
      A_STAT:  rd_mux = stat;
      A_FRM:   rd_mux = frm_q;
      A_DATA:  rd_mux = rx_empty ? '0 : 8'(rx_head[DW-1:0]);
      A_DIVL:  rd_mux = div_q[7:0];
      A_DIVH:  rd_mux = div_q[15:8];
      A_FSTAT: rd_mux = fstat;
      A_FCFG:  rd_mux = fcfg_q;
      A_IEN:   rd_mux = 8'(ien_q);
      A_IST:   rd_mux = 8'(flags & ien_q);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end

  assign port_en_o   = en_q;
  assign frame_cfg_o = frm_q;
  assign divisor_o   = div_q;

  logic unused_ok;
  assign unused_ok = rx_full;
endmodule

// File: rtl/rb_chk.sv
module rb_chk
  import uart_rb_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              tx_pop_i,
  input logic              tx_valid_i,
  input logic              rx_push_i,
  input logic              irq_i,
  input logic              srst_i,
  input logic              tx_full_i,
  input logic              rx_empty_i,
  input logic [CW-1:0]     tx_cnt_i,
  input logic [CW-1:0]     rx_cnt_i,
  input logic [NSRC-1:0]   flags_i,
  input logic [NSRC-1:0]   ien_i
);
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cnt_i <= CW'(DEPTH));

  a_r3_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_i && wr_en_i && addr_i == A_DATA && !(tx_pop_i && tx_valid_i) && !srst_i)
      |=> $stable(tx_cnt_i));

  a_r5_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_i && rd_en_i && addr_i == A_DATA && !rx_push_i) |=> rx_cnt_i == '0);

  a_r10_set_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_FSET && !srst_i)
      |=> ((flags_i & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));

  a_r12_srst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (tx_cnt_i == '0 && rx_cnt_i == '0 && flags_i == '0));

  a_r11_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == '0) |-> !irq_i);

  for (genvar i = 0; i < NSRC; i++) begin : g_fl
    a_r9_flag_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flags_i[i]) |-> $past(srst_i || (wr_en_i && addr_i == A_FCLR && wdata_i[i])));
  end
endmodule

bind uart_fifo_regbank rb_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .tx_pop_i   (tx_pop_i),
  .tx_valid_i (tx_valid_o),
  .rx_push_i  (rx_push_i),
  .irq_i      (irq_o),
  .srst_i     (srst),
  .tx_full_i  (tx_full),
  .rx_empty_i (rx_empty),
  .tx_cnt_i   (tx_cnt),
  .rx_cnt_i   (rx_cnt),
  .flags_i    (flags),
  .ien_i      (ien_q)
);

// File: tb/uart_fifo_regbank_bench.sv
module uart_fifo_regbank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 0, rd_en = 0, tx_pop = 0, tx_idle = 1, rx_push = 0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0, rx_byte = '0;
  logic [2:0] rx_err = '0;
  logic [7:0] rdata, tx_byte, frame_cfg;
  logic [15:0] divisor;
  logic tx_valid, port_en, irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_fifo_regbank u_uart_fifo_regbank (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .tx_byte_o(tx_byte), .tx_valid_o(tx_valid), .tx_pop_i(tx_pop),
    .tx_idle_i(tx_idle), .rx_byte_i(rx_byte), .rx_err_i(rx_err),
    .rx_push_i(rx_push), .port_en_o(port_en), .frame_cfg_o(frame_cfg),
    .divisor_o(divisor), .irq_o(irq));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rdchk(string tag, logic [4:0] a, logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(tag, 16'(d), 16'(exp));
  endtask

  task automatic rxp(logic [7:0] b, logic [2:0] e);
    @(negedge clk); rx_push = 1; rx_byte = b; rx_err = e;
    @(negedge clk); rx_push = 0;
  endtask

  task automatic txpop();
    @(negedge clk); tx_pop = 1;
    @(negedge clk); tx_pop = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
  end

  initial begin
    idle(3); rst_n = 1; idle(2);
    // R1 reset state
    chk("R1 irq", 16'(irq), 0);
    rdchk("R1 fstat", 5'h0A, 8'h84);
    rdchk("R1 fcfg", 5'h0B, 8'h88);
    rdchk("R1 en", 5'h00, 8'h00);
    rdchk("R1 ien", 5'h1E, 8'h00);

    // R13 config passthrough
    wr(5'h03, 8'hA5); wr(5'h08, 8'h34); wr(5'h09, 8'h12);
    chk("R13 frame_cfg_o", 16'(frame_cfg), 16'hA5);
    chk("R13 divisor_o", divisor, 16'h1234);
    rdchk("R13 divl", 5'h08, 8'h34);
    rdchk("R13 divh", 5'h09, 8'h12);
    wr(5'h0A, 8'hFF);
    rdchk("R13 fstat write ignored", 5'h0A, 8'h84);

    // R3 R8 TX fill sweep
    wr(5'h00, 8'h01);
    chk("R1 port_en", 16'(port_en), 1);
    for (int n = 1; n <= 17; n++) begin
      int c;
      c = (n > 16) ? 16 : n;
      wr(5'h04, 8'(n));
      rdchk("R3 R8 tx fstat", 5'h0A,
            8'h04 | ((c == 16) ? 8'h10 : 8'h00) | ((c <= 8) ? 8'h80 : 8'h00));
      chk("R2 tx_valid gated", 16'(tx_valid), 0);
    end
    wr(5'h01, 8'h02);
    rdchk("R14 busy", 5'h02, 8'h00);
    for (int i = 1; i <= 16; i++) begin
      chk("R2 tx_valid", 16'(tx_valid), 1);
      chk("R2 tx order", 16'(tx_byte), 16'(i));
      txpop();
    end
    chk("R3 17th dropped", 16'(tx_valid), 0);
    rdchk("R14 done", 5'h02, 8'h40);
    tx_idle = 0;
    rdchk("R14 engine busy", 5'h02, 8'h00);
    tx_idle = 1;

    // R7 threshold sweep
    for (int thr = 0; thr < 8; thr++) begin
      wr(5'h01, 8'h04); wr(5'h01, 8'h01);
      wr(5'h0B, 8'h88 | 8'(thr));
      rdchk("R6 rx empty", 5'h0A, 8'h84);
      for (int k = 1; k <= 16; k++) begin
        rxp(8'(k), 3'd0);
        rdchk("R7 rx level", 5'h0A, 8'h80 | ((k > 8 + thr) ? 8'h08 : 8'h00));
      end
    end

    // R4 R5 data, error code, overflow
    wr(5'h0B, 8'h88);
    wr(5'h01, 8'h04); wr(5'h01, 8'h01);
    for (int i = 0; i < 17; i++) rxp(8'h30 + 8'(i), 3'(i % 8));
    for (int i = 0; i < 16; i++) begin
      rdchk("R5 head err", 5'h02, 8'h40 | 8'(i % 8));
      rdchk("R4 R5 rx data", 5'h04, 8'h30 + 8'(i));
    end
    rdchk("R5 empty read", 5'h04, 8'h00);
    rdchk("R6 empty again", 5'h0A, 8'h84);
    rdchk("R5 err when empty", 5'h02, 8'h40);

    // R4 disabled drops
    wr(5'h00, 8'h00); rxp(8'h77, 3'd1); wr(5'h00, 8'h01);
    rdchk("R4 port off", 5'h0A, 8'h84);
    wr(5'h01, 8'h00); rxp(8'h78, 3'd1);
    rdchk("R4 rx_en off", 5'h0A, 8'h84);

    // R7 R8 single-entry modes
    wr(5'h01, 8'h01); wr(5'h0B, 8'h00);
    rxp(8'h11, 3'd0);
    rdchk("R7 single rx", 5'h0A, 8'h88);
    rxp(8'h22, 3'd0);
    rdchk("R7 single data", 5'h04, 8'h11);
    rdchk("R7 single drop", 5'h04, 8'h00);
    wr(5'h04, 8'h55);
    rdchk("R8 single tx", 5'h0A, 8'h14);
    wr(5'h04, 8'h66);
    wr(5'h01, 8'h03);
    chk("R8 single byte", 16'(tx_byte), 16'h55);
    txpop();
    chk("R8 single drop", 16'(tx_valid), 0);
    wr(5'h0B, 8'h88);

    // R9 R10 R11 flags
    wr(5'h01, 8'h04); wr(5'h01, 8'h00);
    wr(5'h1E, 8'h00); idle(2);
    chk("R11 masked irq", 16'(irq), 0);
    rdchk("R11 masked ist", 5'h1F, 8'h00);
    wr(5'h1E, 8'h03); idle(2);
    rdchk("R9 tx flag", 5'h1F, 8'h01);
    chk("R11 irq", 16'(irq), 1);
    wr(5'h1C, 8'h01); idle(2);
    rdchk("R9 rearm", 5'h1F, 8'h01);
    for (int i = 0; i < 9; i++) wr(5'h04, 8'(i));
    idle(2);
    rdchk("R9 sticky", 5'h1F, 8'h01);
    wr(5'h1C, 8'h01); idle(2);
    rdchk("R9 cleared", 5'h1F, 8'h00);
    chk("R11 irq low", 16'(irq), 0);
    wr(5'h1D, 8'h02); idle(1);
    rdchk("R10 set rx", 5'h1F, 8'h02);
    chk("R10 irq", 16'(irq), 1);
    wr(5'h1D, 8'h01);
    rdchk("R10 set both", 5'h1F, 8'h03);
    wr(5'h1C, 8'h03); idle(1);
    rdchk("R9 clear both", 5'h1F, 8'h00);
    wr(5'h01, 8'h01);
    for (int i = 0; i < 9; i++) rxp(8'(i), 3'd0);
    idle(2);
    rdchk("R9 rx flag", 5'h1F, 8'h02);
    wr(5'h1E, 8'h00); idle(1);
    chk("R11 mask off", 16'(irq), 0);
    rdchk("R11 ist off", 5'h1F, 8'h00);

    // R12 soft reset
    wr(5'h01, 8'h04); wr(5'h01, 8'h00);
    rdchk("R12 fifos empty", 5'h0A, 8'h84);
    wr(5'h1E, 8'h02); idle(1);
    rdchk("R12 flags cleared", 5'h1F, 8'h00);
    rdchk("R12 data empty", 5'h04, 8'h00);

    summary();
  end
endmodule